// File: doc/BRIEF.md
# DMA Protected Range Filter

This block sits in the path of upstream DMA traffic and decides, for every request it accepts, whether that request may proceed to memory. Software programs a small set of protected windows. Each window has a lower-bound register and an upper-bound register. Addresses are compared at 1 MB granularity, so only the bits above bit 19 take part. A write that lands inside an active window is refused and raises a one-cycle violation pulse. Reads are always let through.

Software must not reprogram a window while non-coherent DMA that passed the filter is still in flight. A serialize command sets a busy status, and the block then stops accepting requests. Busy clears once every accepted, passed, non-snooped request has reported completion. Bound registers accept writes only after such a drain has finished, and only until the next request is accepted.

Top module: `dma_range_guard`

## Requirements
- R1: After reset, every bound register reads with its enable bit (bit 4) set to 1 and its address field zero, the serialize register reads 0, `req_ready` is 1 and `vrd_valid` is 0.
- R2: A bound register reads back its address field in bits 63:20 and its active-low enable in bit 4. Bit 3 always reads 0, meaning read-write. Bits 2:0 and 19:5 read 0 whatever was written. Register index 0 is the serialize register. Index 2+2k is the lower bound of window k, and index 3+2k is its upper bound.
- R3: Address A is inside window k when the enable bits of both of its bound registers are 0 and lower[63:20] ≤ A[63:20] ≤ upper[63:20]. Both ends are inclusive, and A[19:0] is ignored.
- R4: An accepted write inside any active window gets `vrd_pass`=0, snooped or not. `vrd_viol` is 1 for exactly that one verdict cycle.
- R5: Reads, and writes outside every active window, get `vrd_pass`=1 and `vrd_viol`=0. A window with either enable bit at 1 blocks nothing.
- R6: The verdict for a request accepted at clock edge n is presented on `vrd_valid`/`vrd_pass`/`vrd_viol` during the cycle after edge n. `vrd_valid` is 0 in cycles with no acceptance.
- R7: Writing index 0 with bit 1 set starts serialization. From the next cycle, status bit 0 reads 1. Bit 1 always reads 0, so the command can be issued again.
- R8: While status is 1, `req_ready` is 0. Status stays 1 while any passed, non-snooped request has not been retired on `nc_done`. It returns to 0 one cycle after that count reaches zero.
- R9: A write to a bound register is ignored unless a serialization has completed and no request has been accepted since then. This includes all writes after reset and before the first serialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register index |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data for `reg_addr` (combinational) |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Filter can accept a request |
| req_addr | input | ADDR_W | DMA request address |
| req_write | input | 1 | Request modifies memory |
| req_snoop | input | 1 | Request is snooped (coherent) |
| nc_done | input | 1 | One passed non-coherent request has completed |
| vrd_valid | output | 1 | Verdict present |
| vrd_pass | output | 1 | 1 = forward, 0 = refuse |
| vrd_viol | output | 1 | One-cycle pulse for a refused write |

## Verification
On every cycle, assertions check the following. A violation pulse always comes with a refusing verdict. A verdict appears only after an acceptance. Busy status holds while non-coherent work is outstanding, and a start command makes it take effect. Bound registers do not change when a write arrives without permission. The window arithmetic cannot be seen cycle by cycle and is shown only by the bench's scenarios: inclusive limits, ignored low address bits, the need for both enables, and snooped writes being refused. The scenarios also show the drain timing of serialization with requests in flight and the reset read values.

// File: rtl/dmag_pkg.sv
// dmag_pkg: shared constants for the DMA protected range filter.
// Assumes register indices are small; bit positions are fixed by the register layout.
package dmag_pkg;
    localparam int EN_BIT       = 4;   // active-low window enable
    localparam int RO_BIT       = 3;   // access type, reads 0 (read-write)
    localparam int SER_CTRL_BIT = 1;   // serialize command, self-clearing
    localparam int SER_STS_BIT  = 0;   // serialize busy status

    typedef struct packed {
        logic valid;
        logic pass;
        logic viol;
    } verdict_t;
endpackage

// File: rtl/dmag_range_bank.sv
// dmag_range_bank: holds the lower/upper bound registers of every window,
// produces the combinational "inside an active window" flag for the request
// address, and the read view of whichever bound register is addressed.
// Assumes wr_permit already reflects the serialize-before-reprogram rule.
module dmag_range_bank
    import dmag_pkg::*;
#(
    parameter int NUM_RANGES = 2,
    parameter int ADDR_W     = 64,
    parameter int GRAN_BITS  = 20,
    parameter int RA_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              wr_permit,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit,
    output logic [ADDR_W-1:0] rd_data
);
    localparam int FIELD_W = ADDR_W - GRAN_BITS;

    logic [FIELD_W-1:0] lo_f  [NUM_RANGES];
    logic [FIELD_W-1:0] hi_f  [NUM_RANGES];
    logic               lo_dis[NUM_RANGES];
    logic               hi_dis[NUM_RANGES];
    logic [NUM_RANGES-1:0] hit_vec;
    logic [FIELD_W-1:0] req_f;
    logic               wr_ok;
    logic               bits_unused;

    assign req_f       = req_addr[ADDR_W-1:GRAN_BITS];
    assign wr_ok       = reg_we && wr_permit;
    assign bits_unused = ^{req_addr[GRAN_BITS-1:0], reg_wdata[GRAN_BITS-1:EN_BIT+1],
                           reg_wdata[EN_BIT-1:0]};

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_win
        localparam logic [RA_W-1:0] LO_IDX = RA_W'(2 + 2 * i);
        localparam logic [RA_W-1:0] HI_IDX = RA_W'(3 + 2 * i);

        // Lower bound register: reset disabled, written only with permission.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_f[i]   <= '0;
                lo_dis[i] <= 1'b1;
            end else if (wr_ok && reg_addr == LO_IDX) begin
                lo_f[i]   <= reg_wdata[ADDR_W-1:GRAN_BITS];
                lo_dis[i] <= reg_wdata[EN_BIT];
            end
        end

        // Upper bound register: reset disabled, written only with permission.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_f[i]   <= '0;
                hi_dis[i] <= 1'b1;
            end else if (wr_ok && reg_addr == HI_IDX) begin
                hi_f[i]   <= reg_wdata[ADDR_W-1:GRAN_BITS];
                hi_dis[i] <= reg_wdata[EN_BIT];
            end
        end

        // Window match: both enables low and the upper address bits within inclusive bounds.
        assign hit_vec[i] = !lo_dis[i] && !hi_dis[i] &&
                            (req_f >= lo_f[i]) && (req_f <= hi_f[i]);

        // R9: a bound register must not move on a write without permission.
        assert_locked_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && !wr_permit) |=> ($stable(lo_f[i]) && $stable(lo_dis[i])));
        assert_locked_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && !wr_permit) |=> ($stable(hi_f[i]) && $stable(hi_dis[i])));
    end

    assign hit = |hit_vec;

    // Read view: address field on top, active-low enable, access bit and reserved bits zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_RANGES; k++) begin
            if (reg_addr == RA_W'(2 + 2 * k)) begin
                rd_data[ADDR_W-1:GRAN_BITS] = lo_f[k];
                rd_data[EN_BIT]             = lo_dis[k];
            end
            if (reg_addr == RA_W'(3 + 2 * k)) begin
                rd_data[ADDR_W-1:GRAN_BITS] = hi_f[k];
                rd_data[EN_BIT]             = hi_dis[k];
            end
        end
        rd_data[RO_BIT] = 1'b0;
    end
endmodule

// File: rtl/dmag_serializer.sv
// dmag_serializer: counts passed non-coherent requests still in flight, runs
// the busy state of a serialize command, and grants permission to reprogram
// bounds after a completed drain until the next accepted request.
// Assumes nc_done never retires more requests than were counted.
module dmag_serializer #(
    parameter int OUTS_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic accept,
    input  logic inc,
    input  logic dec,
    output logic busy,
    output logic permit
);
    logic [OUTS_W-1:0] outs_q;

    // Outstanding non-coherent request count.
    always_ff @(posedge clk) begin
        if (!rst_n)          outs_q <= '0;
        else if (inc && !dec) outs_q <= outs_q + 1'b1;
        else if (dec && !inc) outs_q <= outs_q - 1'b1;
    end

    // Busy state: set by a start command, cleared once the count is zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                     busy <= 1'b0;
        else if (!busy && start)        busy <= 1'b1;
        else if (busy && outs_q == '0)  busy <= 1'b0;
    end

    // Reprogram permission: granted at drain completion, withdrawn by a new start or acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)                          permit <= 1'b0;
        else if (busy && outs_q == '0)       permit <= 1'b1;
        else if (accept || (!busy && start)) permit <= 1'b0;
    end

    // R8: busy cannot end while non-coherent work is outstanding.
    assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && outs_q != '0) |=> busy);
    // R7: a start command when idle makes status busy on the next cycle.
    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    // R8: the count never retires more than it holds.
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && !inc && outs_q == '0));
    // R8: no request is accepted while busy.
    assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);
endmodule

// File: rtl/dmag_verdict.sv
// dmag_verdict: registers the pass/refuse decision for each accepted request
// and flags which accepted requests add to the non-coherent in-flight count.
// Assumes hit is valid in the cycle the request is accepted.
module dmag_verdict
    import dmag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     accept,
    input  logic     hit,
    input  logic     req_write,
    input  logic     req_snoop,
    output logic     count_inc,
    output verdict_t vrd
);
    logic refuse;

    assign refuse    = req_write && hit;
    assign count_inc = accept && !refuse && !req_snoop;

    // Verdict register: one entry per accepted request, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vrd <= '0;
        end else begin
            vrd.valid <= accept;
            vrd.pass  <= accept && !refuse;
            vrd.viol  <= accept && refuse;
        end
    end

    // R4: a violation pulse always comes with a refusing verdict.
    assert_viol_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vrd.viol |-> (vrd.valid && !vrd.pass));
    // R6: a verdict only follows an acceptance on the previous edge.
    assert_verdict_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vrd.valid |-> $past(accept));
endmodule

// File: rtl/dma_range_guard.sv
// dma_range_guard: top of the DMA protected range filter. Decodes the
// register port, gates request acceptance on serialize status, and connects
// the window bank, the serializer and the verdict stage.
// Assumes one request per cycle at most and that nc_done retires passed
// non-snooped requests only.
module dma_range_guard
    import dmag_pkg::*;
#(
    parameter int NUM_RANGES = 2,
    parameter int ADDR_W     = 64,
    parameter int GRAN_BITS  = 20,
    parameter int OUTS_W     = 8,
    parameter int RA_W       = $clog2(2 * NUM_RANGES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_snoop,
    input  logic              nc_done,
    output logic              vrd_valid,
    output logic              vrd_pass,
    output logic              vrd_viol
);
    logic              busy;
    logic              permit;
    logic              accept;
    logic              ser_start;
    logic              hit;
    logic              count_inc;
    logic [ADDR_W-1:0] bank_rd;
    verdict_t          vrd;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign ser_start = reg_we && reg_addr == '0 && reg_wdata[SER_CTRL_BIT];

    dmag_range_bank #(
        .NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W),
        .GRAN_BITS(GRAN_BITS), .RA_W(RA_W)
    ) bank_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .wr_permit(permit), .req_addr(req_addr),
        .hit(hit), .rd_data(bank_rd)
    );

    dmag_serializer #(.OUTS_W(OUTS_W)) ser_i (
        .clk(clk), .rst_n(rst_n), .start(ser_start), .accept(accept),
        .inc(count_inc), .dec(nc_done), .busy(busy), .permit(permit)
    );

    dmag_verdict vrd_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .hit(hit),
        .req_write(req_write), .req_snoop(req_snoop),
        .count_inc(count_inc), .vrd(vrd)
    );

    // Read mux: serialize register at index 0 shows busy only; bound registers from the bank.
    always_comb begin
        if (reg_addr == '0) begin
            reg_rdata              = '0;
            reg_rdata[SER_STS_BIT] = busy;
        end else begin
            reg_rdata = bank_rd;
        end
    end

    assign vrd_valid = vrd.valid;
    assign vrd_pass  = vrd.pass;
    assign vrd_viol  = vrd.viol;

    // R5: a read is never refused.
    assert_read_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write) |=> (vrd_valid && vrd_pass && !vrd_viol));
endmodule

// File: tb/dma_range_guard_tb.sv
`timescale 1ns/1ps
module dma_range_guard_tb_top;
    localparam int RA_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_snoop = 1'b0;
    logic        nc_done = 1'b0;
    logic        vrd_valid, vrd_pass, vrd_viol;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dma_range_guard dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .req_snoop(req_snoop), .nc_done(nc_done), .vrd_valid(vrd_valid),
        .vrd_pass(vrd_pass), .vrd_viol(vrd_viol)
    );

    function automatic logic [63:0] mk(input logic [43:0] f, input logic dis);
        return {f, 15'b0, dis, 4'b0};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [RA_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [RA_W-1:0] a, output logic [63:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // Drives one request, returns {valid, pass, viol} seen in the verdict cycle.
    task automatic send(input logic [63:0] a, input logic wr, input logic snp,
                        output logic [2:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_snoop = snp;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        v = {vrd_valid, vrd_pass, vrd_viol};
    endtask

    task automatic drain_serialize();
        logic [63:0] d;
        reg_write(0, 64'h2);
        for (int i = 0; i < 20; i++) begin
            reg_read(0, d);
            if (d[0] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [63:0] d;
        reg_read(2, d); chk("R1 lower0 reset", d, 64'h10);
        reg_read(5, d); chk("R1 upper1 reset", d, 64'h10);
        reg_read(0, d); chk("R1 serialize reset", d, 64'h0);
        chk("R1 ready reset", {63'b0, req_ready}, 64'h1);
        chk("R1 verdict idle", {63'b0, vrd_valid}, 64'h0);
    endtask

    task automatic t_locked_at_start();
        logic [63:0] d;
        reg_write(2, mk(44'h100, 1'b0));
        reg_read(2, d); chk("R9 write before serialize ignored", d, 64'h10);
    endtask

    task automatic t_program_layout();
        logic [63:0] d;
        drain_serialize();
        reg_write(2, mk(44'h100, 1'b0) | 64'hFFFEF);
        reg_write(3, mk(44'h1FF, 1'b0));
        reg_write(4, mk(44'h300, 1'b0));
        reg_write(5, mk(44'h300, 1'b1));
        reg_read(2, d); chk("R2 reserved and access bit read 0", d, mk(44'h100, 1'b0));
        reg_read(3, d); chk("R2 upper0 readback", d, mk(44'h1FF, 1'b0));
        reg_read(5, d); chk("R2 upper1 disabled readback", d, mk(44'h300, 1'b1));
    endtask

    task automatic t_bounds();
        logic [2:0] v;
        send({44'h100, 20'h0}, 1'b1, 1'b0, v);     chk("R3 lower edge blocked", v, 3'b101);
        @(negedge clk);
        chk("R4 pulse one cycle", {62'b0, vrd_valid, vrd_viol}, 64'h0);
        send({44'h1FF, 20'hFFFFF}, 1'b1, 1'b0, v); chk("R3 upper inclusive, low bits ignored", v, 3'b101);
        send({44'h0FF, 20'hFFFFF}, 1'b1, 1'b1, v); chk("R3 below lower passes", v, 3'b110);
        send({44'h200, 20'h0}, 1'b1, 1'b1, v);     chk("R3 above upper passes", v, 3'b110);
    endtask

    task automatic t_snoop_and_reads();
        logic [2:0] v;
        send({44'h150, 20'h12345}, 1'b1, 1'b1, v); chk("R4 snooped write blocked", v, 3'b101);
        send({44'h150, 20'h0}, 1'b0, 1'b1, v);     chk("R5 read inside passes", v, 3'b110);
        send({44'h300, 20'h0}, 1'b1, 1'b1, v);     chk("R5 half-enabled window ignored", v, 3'b110);
    endtask

    task automatic t_serialize();
        logic [2:0] v;
        logic [63:0] d;
        send({44'h500, 20'h0}, 1'b0, 1'b0, v);
        send({44'h501, 20'h0}, 1'b1, 1'b0, v);     chk("R6 verdict after accept", v, 3'b110);
        @(negedge clk);
        chk("R6 no verdict when idle", {63'b0, vrd_valid}, 64'h0);
        reg_write(0, 64'h2);
        reg_read(0, d); chk("R7 status set, ctrl reads 0", d, 64'h1);
        chk("R8 ready low while busy", {63'b0, req_ready}, 64'h0);
        nc_done = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        nc_done = 1'b0;
        reg_read(0, d); chk("R8 busy until count seen zero", d, 64'h1);
        @(posedge clk); @(negedge clk);
        reg_read(0, d); chk("R8 busy clears after drain", d, 64'h0);
        chk("R8 ready back", {63'b0, req_ready}, 64'h1);
    endtask

    task automatic t_enable_and_relock();
        logic [2:0] v;
        logic [63:0] d;
        reg_write(5, mk(44'h300, 1'b0));
        send({44'h300, 20'hABCDE}, 1'b1, 1'b0, v); chk("R3 both enables active blocks", v, 3'b101);
        reg_write(2, mk(44'h000, 1'b1));
        reg_read(2, d); chk("R9 write after accept ignored", d, mk(44'h100, 1'b0));
        send({44'h100, 20'h0}, 1'b1, 1'b1, v);     chk("R9 window still active", v, 3'b101);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_at_start();
        t_program_layout();
        t_bounds();
        t_snoop_and_reads();
        t_serialize();
        t_enable_and_relock();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule